// File: doc/BRIEF.md
# Readout Frame Serializer

The block takes one event record, captured in parallel, and sends it out one bit at a time on a single data line. A record is made of a short tag followed by the hit words of three bunch crossings, in a fixed order: the one before the trigger, the triggered one and the one after it. With the default sizes the record is 218 bits long: a 2-bit tag and three 72-bit crossing words.

A holding (master) stage captures the record when the load strobe is accepted. A separate shifting (slave) stage then takes a copy and runs the serial sequence. Because of this split, a new capture never disturbs a record that is being sent. Serial steps are paced by an external shift clock. That clock is sampled in the system clock domain, and a control bit selects its rising or its falling edge as the active edge.

A second control bit selects the line code. In plain mode each record bit is sent once. In balanced mode each bit is sent and then followed by its complement, which keeps the line DC-free and doubles the serial length.

Top module: `psc_readout_top`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, `sdo_o`, `active_o` and `overflow_o` are 0 and both stages are empty. A reset in the middle of a record aborts that record.
- R2: A `load_i` pulse while the block is idle is accepted. `active_o` is still 0 one clock later and is 1 two clocks later, and at that point `sdo_o` already carries the first serial symbol.
- R3: The serial record is the concatenation {tag, previous, current, next}, sent most significant bit first. With `line_plain_i`=1, each active shift-clock edge moves to the next bit, so the record lasts FRAME_W bit periods.
- R4: With `line_plain_i`=0 (balanced), each record bit is sent as the bit and then its inverse on the following active edge, giving 2*FRAME_W symbols.
- R5: `active_o` stays high from the first symbol through the last one. The active edge after the last symbol clears `active_o`. Whenever `active_o` is 0, `sdo_o` is 0.
- R6: With `sclk_inv_i`=0 the rising edge of `sclk_i` is the active edge; with `sclk_inv_i`=1 the falling edge is. An edge of the other polarity changes nothing.
- R7: A `load_i` pulse while a record is pending or being sent makes `overflow_o` high for exactly one clock, one clock later. That load is discarded: the current record continues unchanged and no extra record follows it.
- R8: The line code is captured when a record starts. Changing `line_plain_i` during a record has no effect until the next record.
- R9: The state of `sclk_i` at the time a load is accepted produces no shift; the first shift needs a new active edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tag_i | input | TAG_W | Record tag, sent first |
| bx_prev_i | input | BX_W | Hits of the crossing before the trigger |
| bx_cur_i | input | BX_W | Hits of the triggered crossing |
| bx_next_i | input | BX_W | Hits of the crossing after the trigger |
| load_i | input | 1 | Capture strobe, one clock wide |
| sclk_i | input | 1 | Shift clock, sampled by clk |
| sclk_inv_i | input | 1 | 0: rising edge active, 1: falling edge active |
| line_plain_i | input | 1 | 1: plain code, 0: balanced code |
| sdo_o | output | 1 | Serial data, registered |
| active_o | output | 1 | High while a record is on the line |
| overflow_o | output | 1 | One-clock pulse when a load is discarded |

## Verification
The bench runs a reduced 14-bit record through every combination of edge polarity and line code. It uses three bit patterns: alternating bits, which expose an off-by-one in the bit order; a single walking one, which pins each field to its place in the sequence; and an arithmetic mix, which catches a swap of crossing fields. It samples the line halfway through each shift-clock period and again at the end of the period. The halfway sample shows which edge polarity moved the data, and the end sample gives the symbol sequence, including the inverse symbol in balanced mode. Separate cases cover a load arriving during a record, a line-code change during a record, and a reset in the middle of a record. Each of those cases is followed by a clean record.

// File: rtl/psc_pkg.sv
package psc_pkg;
  typedef enum logic {
    LINE_BALANCED = 1'b0,
    LINE_PLAIN    = 1'b1
  } line_mode_e;
endpackage

// File: rtl/psc_edge_det.sv
module psc_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic sclk_inv_i,
  output logic step_o
);
  logic sclk_q;
  logic now_lvl, was_lvl;

  assign now_lvl = sclk_i ^ sclk_inv_i;
  assign was_lvl = sclk_q ^ sclk_inv_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      step_o <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      step_o <= now_lvl & ~was_lvl;
    end
  end

  // R6: a step never follows two cycles of unchanged shift clock
  assert_step_on_edge_R6: assert property (@(posedge clk) disable iff (rst)
    step_o |-> ($past(sclk_i) != $past(sclk_i, 2)) || $past(rst, 2));
endmodule

// File: rtl/psc_master.sv
module psc_master #(
  parameter int FRAME_W = 218
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               active_i,
  output logic [FRAME_W-1:0] hold_o,
  output logic               start_o,
  output logic               overflow_o
);
  logic pend_q;
  logic busy;

  assign busy    = pend_q | active_i;
  assign start_o = pend_q & ~active_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q     <= 1'b0;
      hold_o     <= '0;
      overflow_o <= 1'b0;
    end else begin
      overflow_o <= load_i & busy;
      if (load_i && !busy) begin
        hold_o <= frame_i;
        pend_q <= 1'b1;
      end else if (start_o) begin
        pend_q <= 1'b0;
      end
    end
  end

  // R7: the held record is untouched while one is being sent
  assert_hold_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    active_i |=> $stable(hold_o));
  // R7: overflow only follows a load
  assert_ovf_from_load_R7: assert property (@(posedge clk) disable iff (rst)
    overflow_o |-> $past(load_i));
endmodule

// File: rtl/psc_slave.sv
module psc_slave
  import psc_pkg::*;
#(
  parameter int FRAME_W = 218
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] hold_i,
  input  logic               step_i,
  input  logic               line_plain_i,
  output logic               sdo_o,
  output logic               active_o
);
  localparam int CW = $clog2(FRAME_W);

  logic [FRAME_W-1:0] shreg_q;
  logic [CW-1:0]      idx_q;
  logic               half_q;
  line_mode_e         mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q  <= '0;
      idx_q    <= '0;
      half_q   <= 1'b0;
      mode_q   <= LINE_PLAIN;
      sdo_o    <= 1'b0;
      active_o <= 1'b0;
    end else if (start_i) begin
      shreg_q  <= hold_i;
      idx_q    <= '0;
      half_q   <= 1'b0;
      mode_q   <= line_mode_e'(line_plain_i);
      sdo_o    <= hold_i[FRAME_W-1];
      active_o <= 1'b1;
    end else if (active_o && step_i) begin
      if (mode_q == LINE_BALANCED && !half_q) begin
        sdo_o  <= ~sdo_o;
        half_q <= 1'b1;
      end else if (idx_q == CW'(FRAME_W-1)) begin
        sdo_o    <= 1'b0;
        active_o <= 1'b0;
        half_q   <= 1'b0;
      end else begin
        shreg_q <= shreg_q << 1;
        sdo_o   <= shreg_q[FRAME_W-2];
        idx_q   <= idx_q + 1'b1;
        half_q  <= 1'b0;
      end
    end
  end

  // R4: the second symbol of a balanced pair is the inverse of the first
  assert_dc_pair_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(half_q) |-> (sdo_o == !$past(sdo_o)));
  // R2: a record starts only on a hand-over from the holding stage
  assert_start_handover_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(active_o) |-> $past(start_i));
  // R5: the line is quiet outside a record
  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !active_o |-> !sdo_o);
endmodule

// File: rtl/psc_readout_top.sv
module psc_readout_top #(
  parameter int TAG_W = 2,
  parameter int BX_W  = 72
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [BX_W-1:0]  bx_prev_i,
  input  logic [BX_W-1:0]  bx_cur_i,
  input  logic [BX_W-1:0]  bx_next_i,
  input  logic             load_i,
  input  logic             sclk_i,
  input  logic             sclk_inv_i,
  input  logic             line_plain_i,
  output logic             sdo_o,
  output logic             active_o,
  output logic             overflow_o
);
  localparam int FRAME_W = TAG_W + 3 * BX_W;

  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] hold;
  logic               start;
  logic               step;

  assign frame = {tag_i, bx_prev_i, bx_cur_i, bx_next_i};

  psc_edge_det u_edge (
    .clk        (clk),
    .rst        (rst),
    .sclk_i     (sclk_i),
    .sclk_inv_i (sclk_inv_i),
    .step_o     (step)
  );

  psc_master #(.FRAME_W(FRAME_W)) u_master (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .frame_i    (frame),
    .active_i   (active_o),
    .hold_o     (hold),
    .start_o    (start),
    .overflow_o (overflow_o)
  );

  psc_slave #(.FRAME_W(FRAME_W)) u_slave (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start),
    .hold_i       (hold),
    .step_i       (step),
    .line_plain_i (line_plain_i),
    .sdo_o        (sdo_o),
    .active_o     (active_o)
  );

  // R1: reset leaves every output low
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> !sdo_o && !active_o && !overflow_o);
endmodule

// File: tb/test_psc_readout_top.sv
module test_psc_readout_top;
  localparam int TAG_W = 2;
  localparam int BX_W  = 4;
  localparam int W     = TAG_W + 3 * BX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TAG_W-1:0] tag_i = '0;
  logic [BX_W-1:0]  bx_prev_i = '0, bx_cur_i = '0, bx_next_i = '0;
  logic load_i = 1'b0, sclk_i = 1'b0, sclk_inv_i = 1'b0, line_plain_i = 1'b1;
  logic sdo_o, active_o, overflow_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  psc_readout_top #(.TAG_W(TAG_W), .BX_W(BX_W)) i_psc_readout_top (
    .clk(clk), .rst(rst), .tag_i(tag_i), .bx_prev_i(bx_prev_i),
    .bx_cur_i(bx_cur_i), .bx_next_i(bx_next_i), .load_i(load_i),
    .sclk_i(sclk_i), .sclk_inv_i(sclk_inv_i), .line_plain_i(line_plain_i),
    .sdo_o(sdo_o), .active_o(active_o), .overflow_o(overflow_o)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // symbol k of the serial sequence, derived from R3 and R4
  function automatic logic sym(input logic [W-1:0] f, input bit bal, input int k);
    if (!bal) return f[W-1-k];
    return (k % 2 == 1) ? ~f[W-1-k/2] : f[W-1-k/2];
  endfunction

  task automatic put(input logic [W-1:0] f);
    {tag_i, bx_prev_i, bx_cur_i, bx_next_i} = f;
  endtask

  task automatic start_frame(input logic [W-1:0] f, input bit bal);
    put(f);
    line_plain_i = !bal;
    load_i = 1'b1;
    tick(1);
    load_i = 1'b0;
    chk("R2 active one clock after load", active_o, 0);
    tick(1);
    chk("R2 active two clocks after load", active_o, 1);
    chk("R3 first symbol", sdo_o, sym(f, bal, 0));
  endtask

  // shift-clock periods k0..k1; after period k the line holds symbol k
  task automatic shift_range(input logic [W-1:0] f, input bit bal, input bit inv,
                             input int k0, input int k1);
    int n = bal ? 2 * W : W;
    for (int k = k0; k <= k1; k++) begin
      sclk_i = 1'b1;
      tick(3);
      if (!inv) begin
        chk("R6 rising edge moves line", sdo_o, (k < n) ? sym(f, bal, k) : 0);
        chk("R5 active at mid period", active_o, (k < n) ? 1 : 0);
      end else begin
        chk("R6 rising edge ignored", sdo_o, sym(f, bal, k - 1));
        chk("R5 active held at mid period", active_o, 1);
      end
      sclk_i = 1'b0;
      tick(3);
      chk(bal ? "R4 balanced symbol" : "R3 plain bit", sdo_o, (k < n) ? sym(f, bal, k) : 0);
      chk("R5 active span", active_o, (k < n) ? 1 : 0);
    end
  endtask

  task automatic full_frame(input logic [W-1:0] f, input bit bal, input bit inv);
    start_frame(f, bal);
    shift_range(f, bal, inv, 1, bal ? 2 * W : W);
    tick(2);
    chk("R5 idle line low", sdo_o, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pats [3];
    logic [W-1:0] g;
    tick(3);
    rst = 1'b0;
    chk("R1 sdo after reset", sdo_o, 0);
    chk("R1 active after reset", active_o, 0);
    chk("R1 overflow after reset", overflow_o, 0);

    // sweep: polarity x line code x patterns
    for (int inv = 0; inv < 2; inv++) begin
      for (int bal = 0; bal < 2; bal++) begin
        for (int p = 0; p < 3; p++) begin
          pats[0] = W'(14'h2AAA);
          pats[1] = W'(1) << ((inv * 5 + bal * 3 + p * 4) % W);
          pats[2] = W'((inv * 7 + bal * 3 + 1) * 1237);
          sclk_inv_i = inv[0];
          tick(2);
          full_frame(pats[p], bal[0], inv[0]);
        end
      end
    end

    // R9: shift clock already high at load gives no shift
    sclk_inv_i = 1'b0;
    g = W'(14'h1C35);
    sclk_i = 1'b1;
    tick(3);
    start_frame(g, 1'b0);
    tick(4);
    chk("R9 no shift from level at load", sdo_o, sym(g, 1'b0, 0));
    sclk_i = 1'b0;
    tick(3);
    chk("R9 falling edge no shift", sdo_o, sym(g, 1'b0, 0));
    shift_range(g, 1'b0, 1'b0, 1, W);

    // R7: load during a record is discarded with an overflow pulse
    g = W'(14'h0F0F);
    start_frame(g, 1'b1);
    shift_range(g, 1'b1, 1'b0, 1, 5);
    put(~g);
    load_i = 1'b1;
    tick(1);
    load_i = 1'b0;
    chk("R7 overflow pulse", overflow_o, 1);
    tick(1);
    chk("R7 overflow one clock", overflow_o, 0);
    shift_range(g, 1'b1, 1'b0, 6, 2 * W);
    tick(10);
    chk("R7 no extra record", active_o, 0);

    // R8: line code change mid-record ignored
    g = W'(14'h2613);
    start_frame(g, 1'b0);
    shift_range(g, 1'b0, 1'b0, 1, 3);
    line_plain_i = 1'b0;
    shift_range(g, 1'b0, 1'b0, 4, W);
    tick(2);
    chk("R8 record length kept", active_o, 0);

    // R1: reset mid-record aborts
    g = W'(14'h3FFF);
    start_frame(g, 1'b0);
    shift_range(g, 1'b0, 1'b0, 1, 3);
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    chk("R1 sdo cleared mid-record", sdo_o, 0);
    chk("R1 active cleared mid-record", active_o, 0);
    sclk_i = 1'b1;
    tick(3);
    sclk_i = 1'b0;
    tick(3);
    chk("R1 stays idle after reset", active_o, 0);
    full_frame(W'(14'h1234), 1'b0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule